// File: doc/BRIEF.md
# Host Inbound Mailbox with Data Interrupt

This block holds message words that a producer sends to a host processor. Words enter through a push port with a valid/ready handshake. They wait in a small shift-register FIFO, where entry 0 always holds the oldest word. The host reaches the block through a simple 32-bit valid/ready register port. It can take the oldest word through a read-to-pop window, look at it through a non-destructive peek register, and read a status word and a config word.

A pop read of an empty mailbox returns a fixed invalid-data marker and changes nothing. The config word holds one writable bit, the data interrupt enable. It also holds a pending flag that tracks whether the mailbox holds any word. One level interrupt line goes to the host, and it is high while the pending flag and the enable are both set.

The FIFO depth and the invalid-data marker are parameters, with defaults of 8 and 32'hFFFF_FFFF. The register window spans 10 address bits, and only word-aligned full 32-bit accesses are decoded.

Top module: `mbx_top`

## Requirements
- R1: The status word (offset 0x98) has bit 31 set exactly when the FIFO holds DEPTH words and bit 30 set exactly when it holds none. All other status bits read zero.
- R2: A read at any of offsets 0x80, 0x84, 0x88 or 0x8C returns the oldest word and removes it. Read data and bus_rsp_valid appear on the clock edge that accepts the request, and bus_ready is always high.
- R3: A pop read of an empty FIFO returns INVALID_WORD and leaves the count and the contents unchanged.
- R4: A read at offset 0x90 returns the oldest word without removing it, and returns INVALID_WORD when the FIFO is empty.
- R5: A write to the config word (offset 0x9C) changes only bit 0, the enable. A config read returns the enable in bit 0, the pending flag in bit 4, and zero in every other bit.
- R6: The pending flag (config bit 4) equals "FIFO not empty" after every clock edge, and irq is high exactly when the pending flag and the enable are both set.
- R7: After reset the FIFO is empty, status reads 32'h4000_0000, peek reads INVALID_WORD, config reads zero, irq is low and push_ready is high.
- R8: Words leave the FIFO in the order they were accepted.
- R9: While the FIFO is full, push_ready is low, and a push attempted then is refused and overwrites no stored word.
- R10: A read at an unmapped or non-word-aligned offset returns zero. A write to any offset other than config (including the pop window, peek and status) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rsp_valid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| push_valid | input | 1 | Producer word offered |
| push_ready | output | 1 | FIFO can accept a word |
| push_data | input | 32 | Producer word |
| irq | output | 1 | Level interrupt to the host |

## Verification
Every effect of a request lands on the clock edge that accepts it. Read data and bus_rsp_valid register on that edge, and so do the FIFO contents, count, enable and pending flag. irq follows from those registers with no added delay. The bench drives each request on a falling edge and withdraws it on the next falling edge. It samples the read data, flags and irq at that second falling edge, one edge after acceptance. State left by a refused push or an ignored write is read back through the peek, status and pop registers before the next stimulus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DATA_W = 32;
    localparam int MBX_ADDR_W = 10;

    // word indices (byte offset >> 2) of the register window
    localparam logic [MBX_ADDR_W-3:0] WIDX_POP_LO = 8'h20;
    localparam logic [MBX_ADDR_W-3:0] WIDX_POP_HI = 8'h23;
    localparam logic [MBX_ADDR_W-3:0] WIDX_PEEK   = 8'h24;
    localparam logic [MBX_ADDR_W-3:0] WIDX_STATUS = 8'h26;
    localparam logic [MBX_ADDR_W-3:0] WIDX_CONFIG = 8'h27;

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_PEND_BIT   = 4;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_POP,
        TGT_PEEK,
        TGT_STATUS,
        TGT_CONFIG
    } mbx_tgt_e;

    typedef struct packed {
        logic                  valid;
        logic                  write;
        mbx_tgt_e              tgt;
        logic [MBX_DATA_W-1:0] wdata;
    } mbx_req_t;

    function automatic mbx_tgt_e mbx_decode(input logic [MBX_ADDR_W-1:0] addr);
        logic [MBX_ADDR_W-3:0] widx;
        widx = addr[MBX_ADDR_W-1:2];
        if (addr[1:0] != 2'b00)
            return TGT_NONE;
        if (widx >= WIDX_POP_LO && widx <= WIDX_POP_HI)
            return TGT_POP;
        if (widx == WIDX_PEEK)
            return TGT_PEEK;
        if (widx == WIDX_STATUS)
            return TGT_STATUS;
        if (widx == WIDX_CONFIG)
            return TGT_CONFIG;
        return TGT_NONE;
    endfunction

endpackage

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int                    DEPTH        = 8,
    parameter logic [MBX_DATA_W-1:0] INVALID_WORD = 32'hFFFF_FFFF,
    localparam int                   CW           = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  logic [MBX_DATA_W-1:0] push_data,
    input  logic                  pop,
    output logic [MBX_DATA_W-1:0] head,
    output logic                  full,
    output logic                  empty,
    output logic                  empty_nxt
);

    logic [MBX_DATA_W-1:0] slot [DEPTH];
    logic [CW-1:0]         count;
    logic [CW-1:0]         count_nxt;
    logic [CW-1:0]         wr_idx;

    assign wr_idx    = count - CW'(pop);
    assign count_nxt = count + CW'(push) - CW'(pop);
    assign empty_nxt = (count_nxt == '0);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [MBX_DATA_W-1:0] shifted;
            if (i + 1 < DEPTH) begin : g_mid
                assign shifted = pop ? slot[i+1] : slot[i];
            end else begin : g_last
                assign shifted = pop ? INVALID_WORD : slot[i];
            end
            always_ff @(posedge clk) begin
                if (rst)
                    slot[i] <= INVALID_WORD;
                else if (push && wr_idx == CW'(i))
                    slot[i] <= push_data;
                else
                    slot[i] <= shifted;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count_nxt;
    end

    assign head  = slot[0];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R9
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R9
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> int'(count) == int'($past(count)) + int'($past(push)) - int'($past(pop))); // R8

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter logic [MBX_DATA_W-1:0] INVALID_WORD = 32'hFFFF_FFFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  mbx_req_t              req,
    input  logic [MBX_DATA_W-1:0] head,
    input  logic                  full,
    input  logic                  empty,
    input  logic                  empty_nxt,
    output logic                  pop,
    output logic                  rsp_valid,
    output logic [MBX_DATA_W-1:0] rdata,
    output logic                  irq
);

    logic                  en_q;
    logic                  pend_q;
    logic                  rd;
    logic [MBX_DATA_W-1:0] rd_mux;

    assign rd  = req.valid && !req.write;
    assign pop = rd && (req.tgt == TGT_POP) && !empty;

    always_comb begin
        rd_mux = '0;
        unique case (req.tgt)
            TGT_POP:    rd_mux = empty ? INVALID_WORD : head;
            TGT_PEEK:   rd_mux = head;
            TGT_STATUS: begin
                rd_mux[STAT_FULL_BIT]  = full;
                rd_mux[STAT_EMPTY_BIT] = empty;
            end
            TGT_CONFIG: begin
                rd_mux[CFG_EN_BIT]   = en_q;
                rd_mux[CFG_PEND_BIT] = pend_q;
            end
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            pend_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rdata     <= '0;
        end else begin
            if (req.valid && req.write && req.tgt == TGT_CONFIG)
                en_q <= req.wdata[CFG_EN_BIT];
            pend_q    <= !empty_nxt;
            rsp_valid <= rd;
            if (rd)
                rdata <= rd_mux;
        end
    end

    assign irq = pend_q && en_q;

    AST_CFG_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.tgt == TGT_CONFIG)
        |=> (en_q == $past(req.wdata[CFG_EN_BIT]))); // R5
    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (rst)
        pend_q == !empty); // R6
    AST_EMPTY_POP_MARK: assert property (@(posedge clk) disable iff (rst)
        (rd && req.tgt == TGT_POP && empty) |=> (rdata == INVALID_WORD)); // R3
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd |=> rsp_valid); // R2

endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int                    DEPTH        = 8,
    parameter logic [MBX_DATA_W-1:0] INVALID_WORD = 32'hFFFF_FFFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    output logic                  bus_ready,
    input  logic                  bus_write,
    input  logic [MBX_ADDR_W-1:0] bus_addr,
    input  logic [MBX_DATA_W-1:0] bus_wdata,
    output logic                  bus_rsp_valid,
    output logic [MBX_DATA_W-1:0] bus_rdata,
    input  logic                  push_valid,
    output logic                  push_ready,
    input  logic [MBX_DATA_W-1:0] push_data,
    output logic                  irq
);

    mbx_req_t              req;
    logic [MBX_DATA_W-1:0] head;
    logic                  full;
    logic                  empty;
    logic                  empty_nxt;
    logic                  pop;
    logic                  push;

    assign bus_ready  = 1'b1;
    assign req.valid  = bus_valid;
    assign req.write  = bus_write;
    assign req.tgt    = mbx_decode(bus_addr);
    assign req.wdata  = bus_wdata;

    assign push_ready = !full;
    assign push       = push_valid && push_ready;

    mbx_store #(
        .DEPTH        (DEPTH),
        .INVALID_WORD (INVALID_WORD)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .full      (full),
        .empty     (empty),
        .empty_nxt (empty_nxt)
    );

    mbx_ctrl #(
        .INVALID_WORD (INVALID_WORD)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .head      (head),
        .full      (full),
        .empty     (empty),
        .empty_nxt (empty_nxt),
        .pop       (pop),
        .rsp_valid (bus_rsp_valid),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

endmodule

// File: tb/sim_mbx_top.sv
`timescale 1ns/1ps
module sim_mbx_top;

    localparam int          DEPTH = 8;
    localparam logic [31:0] INV   = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic        bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rsp_valid;
    logic [31:0] bus_rdata;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [31:0] push_data = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mbx_top #(.DEPTH(DEPTH), .INVALID_WORD(INV)) u0 (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R2 rsp_valid", {31'b0, bus_rsp_valid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic push(input logic [31:0] v, output logic acc);
        @(negedge clk);
        push_valid = 1'b1; push_data = v;
        acc = push_ready;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R7 irq", {31'b0, irq}, 0);
        check("R7 push_ready", {31'b0, push_ready}, 1);
        rd(10'h098, d); check("R7 R1 status", d, 32'h4000_0000);
        rd(10'h090, d); check("R7 R4 peek", d, INV);
        rd(10'h09C, d); check("R7 config", d, 0);
    endtask

    task automatic t_empty_pop();
        logic [31:0] d;
        rd(10'h080, d); check("R3 empty pop", d, INV);
        rd(10'h098, d); check("R3 status after", d, 32'h4000_0000);
        rd(10'h08C, d); check("R3 empty pop hi", d, INV);
    endtask

    task automatic t_order();
        logic [31:0] d;
        logic a;
        push(32'h1111_0001, a); check("R8 acc", {31'b0, a}, 1);
        push(32'h2222_0002, a);
        push(32'h3333_0003, a);
        rd(10'h090, d); check("R4 peek", d, 32'h1111_0001);
        rd(10'h090, d); check("R4 peek again", d, 32'h1111_0001);
        rd(10'h098, d); check("R1 status mid", d, 0);
        rd(10'h084, d); check("R2 R8 pop1", d, 32'h1111_0001);
        rd(10'h088, d); check("R2 R8 pop2", d, 32'h2222_0002);
        rd(10'h08C, d); check("R2 R8 pop3", d, 32'h3333_0003);
        rd(10'h098, d); check("R1 status empty", d, 32'h4000_0000);
        rd(10'h090, d); check("R4 peek empty", d, INV);
    endtask

    task automatic t_full();
        logic [31:0] d;
        logic a;
        for (int i = 0; i < DEPTH; i++) push(32'hA000_0000 + i, a);
        rd(10'h098, d); check("R1 status full", d, 32'h8000_0000);
        check("R9 push_ready low", {31'b0, push_ready}, 0);
        push(32'hDEAD_BEEF, a); check("R9 refused", {31'b0, a}, 0);
        rd(10'h090, d); check("R9 head kept", d, 32'hA000_0000);
        for (int i = 0; i < DEPTH; i++) begin
            rd(10'h080, d); check("R9 R8 drain", d, 32'hA000_0000 + i);
        end
        rd(10'h080, d); check("R9 no extra", d, INV);
    endtask

    task automatic t_config();
        logic [31:0] d;
        logic a;
        wr(10'h09C, 32'hFFFF_FFFE);
        rd(10'h09C, d); check("R5 only bit0", d, 0);
        wr(10'h09C, 32'h0000_0001);
        rd(10'h09C, d); check("R5 en set", d, 32'h1);
        check("R6 irq empty", {31'b0, irq}, 0);
        push(32'h5555_AAAA, a);
        check("R6 irq after push", {31'b0, irq}, 1);
        rd(10'h09C, d); check("R5 R6 cfg pend", d, 32'h11);
        rd(10'h080, d); check("R6 pop word", d, 32'h5555_AAAA);
        check("R6 irq after pop", {31'b0, irq}, 0);
        push(32'h0000_0077, a);
        wr(10'h09C, 32'h0000_0010);
        check("R6 irq disabled", {31'b0, irq}, 0);
        rd(10'h09C, d); check("R5 cfg pend only", d, 32'h10);
        rd(10'h080, d); check("R6 cleanup", d, 32'h77);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic a;
        push(32'hCAFE_0001, a);
        wr(10'h080, 32'h1234_5678);
        wr(10'h090, 32'h1234_5678);
        wr(10'h098, 32'hFFFF_FFFF);
        wr(10'h000, 32'h1234_5678);
        rd(10'h000, d); check("R10 unmapped 0", d, 0);
        rd(10'h094, d); check("R10 unmapped 94", d, 0);
        rd(10'h082, d); check("R10 misaligned", d, 0);
        rd(10'h098, d); check("R10 status kept", d, 0);
        rd(10'h09C, d); check("R10 config kept", d, 32'h10);
        rd(10'h090, d); check("R10 head kept", d, 32'hCAFE_0001);
        rd(10'h080, d); check("R10 pop", d, 32'hCAFE_0001);
        rd(10'h080, d); check("R10 nothing added", d, INV);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_empty_pop();
        t_order();
        t_full();
        t_config();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule